// File: doc/BRIEF.md
# Pin Interrupt Detector

This block watches a bank of general-purpose input pins and turns level conditions or edges on them into interrupt requests. The bank is split into halves of sixteen pins. Each half has its own set of sixteen-bit configuration, enable and status registers on a simple register bus. For every pin, software chooses edge or level detection, the active level, which edges count, and whether a detected event stays latched until software clears it.

The pins come in asynchronously and go through a synchroniser. Edges are found by comparing the synchronised value with its value one clock earlier. Each half updates its status bits from these events. A pin is pending when its status bit and its enable bit are both set. The block drives one combined interrupt line and the index of the lowest pending pin, with a valid flag. The valid flag lets an interrupt handler tell a spurious entry from a real one.

Software normally programs the mode registers, clears any stale status and then sets the enables. The interrupt service routine reads the pending index and clears the latched bit by writing a one to it.

Top module: `pin_irq_detect`

## Requirements
- R1: While reset is applied and at its release, every register reads 0, and the interrupt line and valid flag are 0.
- R2: A change on a pin input shows in that pin's status bit at the third rising clock edge after the change is sampled: two synchroniser flops plus the status register.
- R3: A pin whose type bit is 0 is level-detected. Its status bit equals 1 exactly when the synchronised input equals its polarity bit (1 = active high, 0 = active low). The status bit is never latched, so writing 1 to it has no lasting effect.
- R4: A pin whose type bit is 1 is edge-detected. A 0-to-1 transition counts only if its rising-select bit is 1, and a 1-to-0 transition counts only if its falling-select bit is 1. With both bits set, both transitions count.
- R5: For an edge-detected pin whose hold bit is 1, a counted edge sets the status bit. The bit then stays set until a bus write of 1 to that bit position in the status register. Writing 0 leaves it unchanged.
- R6: For an edge-detected pin whose hold bit is 0, the status bit is 1 for exactly the one cycle that follows each counted edge.
- R7: When a counted edge and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: The interrupt output is 1 exactly when some pin has both its status bit and its enable bit set.
- R9: The pending index is the lowest pending pin, with bits 0..15 taking precedence over 16..31. A high-half pin is reported as 16 plus its bit position. The valid flag is 1 exactly when some pin is pending.
- R10: Register address bit 3 selects the half (0 = pins 0..15, 1 = pins 16..31). Address bits 2:0 select the register: 0 enable, 1 status, 2 type, 3 polarity, 4 hold, 5 falling-select, 6 rising-select. Code 7 reads 0. Reads are combinational, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous pin inputs |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address (half, register code) |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i |
| irq_o | output | 1 | Combined interrupt request |
| pend_idx_o | output | 5 | Lowest pending pin index |
| pend_valid_o | output | 1 | Pending index is meaningful |

## Verification
A corrupted status or configuration bit shows up at the ports in the very next cycle. It appears on the combined interrupt line, on the pending index, or in the combinational read data of the affected register. A wrong synchroniser depth or a missing edge register shifts the status update away from the third edge after a pin change, and the cycle-accurate reference catches that shift at once. A wrong priority or offset in the index shows as soon as both halves hold pending pins. A lost edge-versus-clear race leaves a latched bit reading 0 right after the write.

// File: rtl/pid_pkg.sv
package pid_pkg;
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      REG_EN   = 3'd0,
      REG_ST   = 3'd1,
      REG_TYP  = 3'd2,
      REG_POL  = 3'd3,
      REG_HOLD = 3'd4,
      REG_FALL = 3'd5,
      REG_RISE = 3'd6,
      REG_NONE = 3'd7
   } pid_reg_e;
endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prev_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pid_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
         prev_q <= '0;
      end else begin
         chain_q[0] <= raw_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         prev_q <= chain_q[STAGES-1];
      end
   end

   assign cur_o  = chain_q[STAGES-1];
   assign prev_o = prev_q;
endmodule

// File: rtl/pid_half.sv
module pid_half
   import pid_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  pid_reg_e     sel_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] cur_i,
   input  logic [W-1:0] prev_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] enable_o,
   output logic [W-1:0] rdata_o
);
   if (W < 1) begin : g_bad_w
      $error("pid_half: W must be positive");
   end

   logic [W-1:0] en_q, typ_q, pol_q, hold_q, fall_q, rise_q, st_q;
   logic [W-1:0] clr, ev, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         typ_q  <= '0;
         pol_q  <= '0;
         hold_q <= '0;
         fall_q <= '0;
         rise_q <= '0;
      end else if (wr_i) begin
         case (sel_i)
            REG_EN:   en_q   <= wdata_i;
            REG_TYP:  typ_q  <= wdata_i;
            REG_POL:  pol_q  <= wdata_i;
            REG_HOLD: hold_q <= wdata_i;
            REG_FALL: fall_q <= wdata_i;
            REG_RISE: rise_q <= wdata_i;
            default: ;
         endcase
      end
   end

   assign clr = (wr_i && sel_i == REG_ST) ? wdata_i : '0;

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic went_up, went_down, lvl_hit;
      assign went_up   = cur_i[i] & ~prev_i[i];
      assign went_down = ~cur_i[i] & prev_i[i];
      assign lvl_hit   = ~(cur_i[i] ^ pol_q[i]);
      assign ev[i]     = (went_up & rise_q[i]) | (went_down & fall_q[i]);

      always_comb begin
         if (!typ_q[i])      st_d[i] = lvl_hit;
         else if (hold_q[i]) st_d[i] = ev[i] | (st_q[i] & ~clr[i]);
         else                st_d[i] = ev[i];
      end

      assert_level_follow_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         (!typ_q[i] && (cur_i[i] == pol_q[i])) |=> st_q[i]);
      assert_level_drop_R3 : assert property (@(posedge clk) disable iff (!rst_n)
         (!typ_q[i] && (cur_i[i] != pol_q[i])) |=> !st_q[i]);
      assert_hold_keep_R5 : assert property (@(posedge clk) disable iff (!rst_n)
         (typ_q[i] && hold_q[i] && st_q[i] && !clr[i]) |=> st_q[i]);
      assert_pulse_end_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (typ_q[i] && !hold_q[i] && !ev[i]) |=> !st_q[i]);
      assert_edge_wins_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         (typ_q[i] && ev[i]) |=> st_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   always_comb begin
      case (sel_i)
         REG_EN:   rdata_o = en_q;
         REG_ST:   rdata_o = st_q;
         REG_TYP:  rdata_o = typ_q;
         REG_POL:  rdata_o = pol_q;
         REG_HOLD: rdata_o = hold_q;
         REG_FALL: rdata_o = fall_q;
         REG_RISE: rdata_o = rise_q;
         default:  rdata_o = '0;
      endcase
   end

   assign status_o = st_q;
   assign enable_o = en_q;
endmodule

// File: rtl/pid_prio.sv
module pid_prio #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     pend_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             valid_o
);
   if (N < 2) begin : g_bad_n
      $error("pid_prio: N must be at least 2");
   end

   always_comb begin
      idx_o   = '0;
      valid_o = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            idx_o   = IDX_W'(i);
            valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
   import pid_pkg::*;
#(
   parameter int HALF_W      = 16,
   parameter int N_HALVES    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int N     = HALF_W * N_HALVES,
   localparam int IDX_W = $clog2(N),
   localparam int HSW   = (N_HALVES > 1) ? $clog2(N_HALVES) : 1,
   localparam int AW    = REG_IDX_W + HSW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      pins_i,
   input  logic              bus_we_i,
   input  logic [AW-1:0]     bus_addr_i,
   input  logic [HALF_W-1:0] bus_wdata_i,
   output logic [HALF_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic [IDX_W-1:0]  pend_idx_o,
   output logic              pend_valid_o
);
   if (HALF_W < 1 || N_HALVES < 1 || N < 2) begin : g_bad_geom
      $error("pin_irq_detect: bad geometry parameters");
   end

   logic [N-1:0]      cur, prev, st_all, en_all, pend_vec;
   logic [HSW-1:0]    half_sel;
   pid_reg_e          reg_sel;
   logic [HALF_W-1:0] rd_arr [2**HSW];

   assign half_sel = bus_addr_i[AW-1:REG_IDX_W];
   assign reg_sel  = pid_reg_e'(bus_addr_i[REG_IDX_W-1:0]);

   pid_sync #(.W(N), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .raw_i(pins_i), .cur_o(cur), .prev_o(prev)
   );

   for (genvar h = 0; h < 2**HSW; h++) begin : g_half
      if (h < N_HALVES) begin : g_real
         pid_half #(.W(HALF_W)) half_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (bus_we_i && (half_sel == HSW'(h))),
            .sel_i    (reg_sel),
            .wdata_i  (bus_wdata_i),
            .cur_i    (cur[h*HALF_W +: HALF_W]),
            .prev_i   (prev[h*HALF_W +: HALF_W]),
            .status_o (st_all[h*HALF_W +: HALF_W]),
            .enable_o (en_all[h*HALF_W +: HALF_W]),
            .rdata_o  (rd_arr[h])
         );
      end else begin : g_empty
         assign rd_arr[h] = '0;
      end
   end

   assign bus_rdata_o = rd_arr[half_sel];
   assign pend_vec    = st_all & en_all;
   assign irq_o       = |pend_vec;

   pid_prio #(.N(N), .IDX_W(IDX_W)) prio_i (
      .pend_i(pend_vec), .idx_o(pend_idx_o), .valid_o(pend_valid_o)
   );

   logic [N-1:0] below_mask;
   assign below_mask = (N'(1) << pend_idx_o) - N'(1);

   assert_irq_valid_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == pend_valid_o);
   assert_idx_set_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid_o |-> pend_vec[pend_idx_o]);
   assert_idx_lowest_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid_o |-> ((pend_vec & below_mask) == '0));

   always @(posedge clk) begin
      if (!rst_n) assert_reset_quiet_R1 : assert (!irq_o && !pend_valid_o);
   end
endmodule

// File: tb/pin_irq_detect_tb.sv
`timescale 1ns/1ps
module pin_irq_detect_tb_top;
   localparam int N  = 32;
   localparam int HW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic          we = 1'b0;
   logic [3:0]    addr = '0;
   logic [HW-1:0] wdata = '0;
   logic [HW-1:0] rdata;
   logic          irq, pval;
   logic [4:0]    pidx;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   pin_irq_detect dut_i (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .pend_idx_o(pidx), .pend_valid_o(pval)
   );

   // behavioural reference, updated at every rising edge
   logic [N-1:0] m_en, m_st, m_typ, m_pol, m_hold, m_fall, m_rise;
   logic [N-1:0] hist [$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_st = '0; m_typ = '0; m_pol = '0;
         m_hold = '0; m_fall = '0; m_rise = '0;
         hist.delete();
         for (int k = 0; k < 3; k++) hist.push_back('0);
      end else begin
         logic [N-1:0] nowv, oldv, clrv, nst;
         int h;
         nowv = hist[1];
         oldv = hist[2];
         h = addr[3];
         clrv = '0;
         if (we && addr[2:0] == 3'd1) clrv[h*HW +: HW] = wdata;
         for (int i = 0; i < N; i++) begin
            logic hit;
            hit = (nowv[i] && !oldv[i] && m_rise[i]) || (!nowv[i] && oldv[i] && m_fall[i]);
            if (!m_typ[i])      nst[i] = (nowv[i] == m_pol[i]);
            else if (m_hold[i]) nst[i] = hit || (m_st[i] && !clrv[i]);
            else                nst[i] = hit;
         end
         if (we) begin
            case (addr[2:0])
               3'd0: m_en[h*HW +: HW]   = wdata;
               3'd2: m_typ[h*HW +: HW]  = wdata;
               3'd3: m_pol[h*HW +: HW]  = wdata;
               3'd4: m_hold[h*HW +: HW] = wdata;
               3'd5: m_fall[h*HW +: HW] = wdata;
               3'd6: m_rise[h*HW +: HW] = wdata;
               default: ;
            endcase
         end
         m_st = nst;
         hist.push_front(pins);
         void'(hist.pop_back());
      end
   end

   function automatic logic [HW-1:0] m_read(input logic [3:0] a);
      int h = a[3];
      case (a[2:0])
         3'd0: return m_en[h*HW +: HW];
         3'd1: return m_st[h*HW +: HW];
         3'd2: return m_typ[h*HW +: HW];
         3'd3: return m_pol[h*HW +: HW];
         3'd4: return m_hold[h*HW +: HW];
         3'd5: return m_fall[h*HW +: HW];
         3'd6: return m_rise[h*HW +: HW];
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
      end
   endtask

   // cycle-by-cycle comparison in the middle of the high phase
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         logic [N-1:0] pv;
         int lo;
         pv = m_st & m_en;
         lo = 0;
         for (int i = N - 1; i >= 0; i--) if (pv[i]) lo = i;
         chk("R8 irq", {31'd0, irq}, {31'd0, |pv});
         chk("R9 valid", {31'd0, pval}, {31'd0, |pv});
         if (|pv) chk("R9 index", {27'd0, pidx}, lo);
         chk("R10 read", {16'd0, rdata}, {16'd0, m_read(addr)});
      end
   end

   task automatic wr(input logic [3:0] a, input logic [HW-1:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rdm(input string req, input logic [3:0] a, input logic [HW-1:0] mask,
                      input logic [HW-1:0] exp);
      @(negedge clk); addr = a; #1;
      chk(req, {16'd0, rdata & mask}, {16'd0, exp});
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      idle(3);
      addr = 4'd1; #1;
      chk("R1 status in reset", {16'd0, rdata}, 32'd0);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      chk("R1 valid in reset", {31'd0, pval}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      rdm("R1 low enable", 4'd0, 16'hFFFF, 16'h0000);
      rdm("R1 high enable", 4'd8, 16'hFFFF, 16'h0000);

      // configuration of both halves
      wr(4'd2, 16'h0290); wr(4'd3, 16'h0001); wr(4'd4, 16'h0090);
      wr(4'd5, 16'h0280); wr(4'd6, 16'h0210);
      wr(4'd10, 16'h0004); wr(4'd12, 16'h0004); wr(4'd13, 16'h0004); wr(4'd14, 16'h0004);
      rdm("R10 type readback", 4'd2, 16'hFFFF, 16'h0290);
      rdm("R10 rise readback high", 4'd14, 16'hFFFF, 16'h0004);
      rdm("R10 code 7 reads zero", 4'd7, 16'hFFFF, 16'h0000);
      wr(4'd0, 16'h0291); wr(4'd8, 16'h0004);

      // R3 level detection, active-low default on pin 1, active-high pin 0
      rdm("R3 active-low idle", 4'd1, 16'h0003, 16'h0002);
      // R2 latency on pin 0
      @(negedge clk); pins[0] = 1'b1; addr = 4'd1;
      @(negedge clk); #1 chk("R2 after 1 edge", {31'd0, rdata[0]}, 32'd0);
      @(negedge clk); #1 chk("R2 after 2 edges", {31'd0, rdata[0]}, 32'd0);
      @(negedge clk); #1 chk("R2 after 3 edges", {31'd0, rdata[0]}, 32'd1);
      wr(4'd1, 16'h0001);
      rdm("R3 clear has no lasting effect", 4'd1, 16'h0001, 16'h0001);
      @(negedge clk); pins[1] = 1'b1; idle(4);
      rdm("R3 active-low released", 4'd1, 16'h0002, 16'h0000);

      // R9 priority across halves: pin 0 pending, high bit 2 not yet
      chk("R9 low pin first", {27'd0, pidx}, 32'd0);
      @(negedge clk); pins[18] = 1'b1; idle(4);
      chk("R9 low still first", {27'd0, pidx}, 32'd0);
      @(negedge clk); pins[0] = 1'b0; idle(4);
      chk("R9 high index offset", {27'd0, pidx}, 32'd18);
      chk("R8 irq with high pending", {31'd0, irq}, 32'd1);

      // R4 edge selection
      @(negedge clk); pins[4] = 1'b1; idle(4);
      rdm("R4 rising counted", 4'd1, 16'h0010, 16'h0010);
      @(negedge clk); pins[7] = 1'b1; idle(4);
      rdm("R4 rise ignored on falling-only", 4'd1, 16'h0080, 16'h0000);
      @(negedge clk); pins[7] = 1'b0; idle(4);
      rdm("R4 falling counted", 4'd1, 16'h0080, 16'h0080);

      // R5 latching and clearing
      wr(4'd1, 16'h0000);
      rdm("R5 write 0 keeps", 4'd1, 16'h0010, 16'h0010);
      wr(4'd1, 16'h0010);
      rdm("R5 write 1 clears", 4'd1, 16'h0010, 16'h0000);
      wr(4'd9, 16'h0004);
      chk("R9 spurious valid low", {31'd0, pval}, {31'd0, irq});

      // R6 pulse on both-edge pin without hold
      @(negedge clk); pins[9] = 1'b1; addr = 4'd1;
      idle(2);
      @(negedge clk); #1 chk("R6 pulse set", {31'd0, rdata[9]}, 32'd1);
      @(negedge clk); #1 chk("R6 pulse gone", {31'd0, rdata[9]}, 32'd0);
      @(negedge clk); pins[9] = 1'b0; idle(4);

      // R7 edge and clear in the same cycle
      @(negedge clk); pins[4] = 1'b0; idle(4);
      @(negedge clk); pins[4] = 1'b1; idle(4);
      @(negedge clk); pins[4] = 1'b0; idle(4);
      @(negedge clk); pins[4] = 1'b1;
      @(negedge clk);
      @(negedge clk); addr = 4'd1; wdata = 16'h0010; we = 1'b1;
      @(negedge clk); we = 1'b0;
      rdm("R7 edge beats clear", 4'd1, 16'h0010, 16'h0010);

      // disable everything: no pending
      wr(4'd0, 16'h0000); wr(4'd8, 16'h0000);
      idle(1);
      chk("R8 irq off when disabled", {31'd0, irq}, 32'd0);
      chk("R9 valid off when disabled", {31'd0, pval}, 32'd0);
      idle(3);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule